// File: doc/BRIEF.md
# Pipeline Input Recovery Tracker

This block sits next to a fixed-latency evaluation pipeline that scores candidate solutions. A generator feeds one 64-bit candidate per cycle. The pipeline returns a quality score a fixed number of cycles later. When a score reaches a programmable threshold, the tracker stops taking new candidates and presents the candidate that earned that score.

The block does not carry each wide candidate through every stage. It parks the candidate in a small ring store whose depth is the latency plus two, rounded up to a power of two. Only the short slot index travels down the pipeline, together with a one-bit valid flag. The valid flag hides results while the pipeline fills after reset or restart, and it also hides results for cycles in which no candidate entered.

A build option replaces the ring store with arithmetic recovery, for use with a generator that counts up by one every cycle. In that mode the presented candidate is the value entering in the match cycle minus the latency. The scoring itself is a stand-in stub in this project. It splits the candidate so that the bench can steer its scores.

Top module: `cand_recovery_tracker`

## Requirements
- R1: A candidate accepted in cycle c (in_valid and in_ready both high) yields res_valid high in cycle c+LATENCY. In that cycle res_quality equals the bitwise XOR of candidate bits [QUAL_W-1:0] and bits [CAND_W-1:CAND_W-QUAL_W].
- R2: After reset or restart, res_valid stays low until a result from a candidate accepted after that point emerges, so it is low for at least the first LATENCY cycles. While res_valid is low, res_quality reads zero.
- R3: A cycle in which no candidate is accepted produces res_valid low LATENCY cycles later.
- R4: found_valid rises in the cycle after the first valid result whose quality is greater than or equal to threshold, compared as unsigned. A result one below threshold does not set it.
- R5: In buffer mode (RECOVER = RECOVER_BUFFER), found_cand equals the candidate that produced the first qualifying result, even when idle cycles are mixed into the input stream.
- R6: While found_valid is high, in_ready is low and offered candidates are not taken. found_valid and found_cand hold unchanged until restart, whatever later results arrive.
- R7: A restart pulse clears found_valid, raises in_ready and drops every result still in flight, so res_valid is low in the cycles that follow.
- R8: In arithmetic mode (RECOVER = RECOVER_ARITH), with a generator that increments by one every cycle, found_cand equals the candidate entering in the match cycle minus LATENCY.
- R9: After reset, found_valid and res_valid are low and in_ready is high.
- R10: In buffer mode, a ring slot is never rewritten while its index is still in flight: an emerging valid tag never equals the current write slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous clear of the found state and in-flight results |
| threshold | input | QUAL_W | Minimum unsigned quality that counts as a match |
| in_valid | input | 1 | Generator offers a candidate |
| in_cand | input | CAND_W | Offered candidate |
| in_ready | output | 1 | Candidate is taken when high together with in_valid |
| res_valid | output | 1 | Masked pipeline result valid |
| res_quality | output | QUAL_W | Pipeline quality result, zero when not valid |
| found_valid | output | 1 | A match has been captured |
| found_cand | output | CAND_W | Candidate that produced the match |

## Verification
The main instance uses the default 16-stage latency, 64-bit candidates and buffer recovery. Its 32-slot ring then wraps several times within a stream that mixes in idle cycles, so the no-overwrite margin and the tag lookup are exercised after wraparound. A second instance uses a latency of 4 with arithmetic recovery and is fed a gapless counter. This makes the subtraction path reachable, and its match appears within a few cycles. Threshold values sit exactly at a score, one below a score and one above a score, to pin down the unsigned greater-or-equal boundary.

// File: rtl/crt_pkg.sv
package crt_pkg;

   typedef enum logic [0:0] {
      RECOVER_BUFFER = 1'b0,
      RECOVER_ARITH  = 1'b1
   } recover_e;

   // Ring depth: latency plus two slots of margin, rounded up to a power of two.
   function automatic int ring_depth(input int latency);
      return 1 << $clog2(latency + 2);
   endfunction

endpackage

// File: rtl/crt_tag_shift.sv
module crt_tag_shift #(
   parameter int STAGES = 16,
   parameter int TAG_W  = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             flush,
   input  logic             in_valid,
   input  logic [TAG_W-1:0] in_tag,
   output logic             out_valid,
   output logic [TAG_W-1:0] out_tag
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("crt_tag_shift: STAGES must be at least 1");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("crt_tag_shift: TAG_W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] vld_q;
   logic [TAG_W-1:0]  tag_q [STAGES];

   // Valid flags reset so the output stays masked during fill.
   always_ff @(posedge clk) begin
      if (rst || flush) begin
         vld_q <= '0;
      end else begin
         vld_q[0] <= in_valid;
         for (int s = 1; s < STAGES; s++) begin
            vld_q[s] <= vld_q[s-1];
         end
      end
   end

   // Tag data needs no reset: it is qualified by the valid flag.
   always_ff @(posedge clk) begin
      tag_q[0] <= in_tag;
      for (int s = 1; s < STAGES; s++) begin
         tag_q[s] <= tag_q[s-1];
      end
   end

   assign out_valid = vld_q[STAGES-1];
   assign out_tag   = tag_q[STAGES-1];

endmodule

// File: rtl/crt_quality_stub.sv
module crt_quality_stub #(
   parameter int STAGES = 16,
   parameter int QUAL_W = 16
) (
   input  logic              clk,
   input  logic [QUAL_W-1:0] cand_lo,
   input  logic [QUAL_W-1:0] cand_hi,
   output logic [QUAL_W-1:0] quality
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("crt_quality_stub: STAGES must be at least 1");
      end
   endgenerate

   logic [QUAL_W-1:0] q_q [STAGES];

   // Stand-in scoring: fold of two candidate slices, then a plain delay line.
   always_ff @(posedge clk) begin
      q_q[0] <= cand_lo ^ cand_hi;
      for (int s = 1; s < STAGES; s++) begin
         q_q[s] <= q_q[s-1];
      end
   end

   assign quality = q_q[STAGES-1];

endmodule

// File: rtl/crt_cand_ring.sv
module crt_cand_ring #(
   parameter int CAND_W = 64,
   parameter int DEPTH  = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [CAND_W-1:0] wr_data,
   output logic [IDX_W-1:0]  wr_idx,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CAND_W-1:0] rd_data
);

   generate
      if (DEPTH != (1 << IDX_W)) begin : g_bad_depth
         $error("crt_cand_ring: DEPTH must equal 2**IDX_W");
      end
   endgenerate

   logic [CAND_W-1:0] mem_q [DEPTH];
   logic [IDX_W-1:0]  wp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q <= '0;
      end else if (wr_en) begin
         wp_q <= wp_q + IDX_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[wp_q] <= wr_data;
      end
   end

   assign wr_idx  = wp_q;
   assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/cand_recovery_tracker.sv
module cand_recovery_tracker
   import crt_pkg::*;
#(
   parameter int       LATENCY = 16,
   parameter int       CAND_W  = 64,
   parameter int       QUAL_W  = 16,
   parameter recover_e RECOVER = RECOVER_BUFFER
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              restart,
   input  logic [QUAL_W-1:0] threshold,
   input  logic              in_valid,
   input  logic [CAND_W-1:0] in_cand,
   output logic              in_ready,
   output logic              res_valid,
   output logic [QUAL_W-1:0] res_quality,
   output logic              found_valid,
   output logic [CAND_W-1:0] found_cand
);

   localparam int DEPTH  = ring_depth(LATENCY);
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int WARM_W = $clog2(LATENCY + 1);

   generate
      if (LATENCY < 1) begin : g_bad_latency
         $error("cand_recovery_tracker: LATENCY must be at least 1");
      end
      if (QUAL_W > CAND_W) begin : g_bad_qual
         $error("cand_recovery_tracker: QUAL_W must not exceed CAND_W");
      end
      if (IDX_W > CAND_W) begin : g_bad_idx
         $error("cand_recovery_tracker: ring index wider than candidate");
      end
      if (DEPTH < LATENCY + 2) begin : g_bad_margin
         $error("cand_recovery_tracker: ring depth below latency plus two");
      end
   endgenerate

   logic              accept;
   logic [IDX_W-1:0]  tag_in;
   logic [IDX_W-1:0]  res_tag;
   logic              pipe_valid;
   logic [QUAL_W-1:0] pipe_quality;
   logic [CAND_W-1:0] pick;
   logic              match_now;
   logic              found_q;
   logic [CAND_W-1:0] found_cand_q;
   logic [WARM_W-1:0] warm_q;

   assign in_ready = !found_q;
   assign accept   = in_valid && in_ready;

   crt_tag_shift #(
      .STAGES (LATENCY),
      .TAG_W  (IDX_W)
   ) tag_path_i (
      .clk       (clk),
      .rst       (rst),
      .flush     (restart),
      .in_valid  (accept),
      .in_tag    (tag_in),
      .out_valid (pipe_valid),
      .out_tag   (res_tag)
   );

   crt_quality_stub #(
      .STAGES (LATENCY),
      .QUAL_W (QUAL_W)
   ) score_i (
      .clk     (clk),
      .cand_lo (in_cand[QUAL_W-1:0]),
      .cand_hi (in_cand[CAND_W-1 -: QUAL_W]),
      .quality (pipe_quality)
   );

   assign res_valid   = pipe_valid;
   assign res_quality = pipe_valid ? pipe_quality : '0;

   // Recovery variant: ring lookup by tag, or counter arithmetic.
   generate
      if (RECOVER == RECOVER_BUFFER) begin : g_ring
         logic [IDX_W-1:0] wr_idx;

         crt_cand_ring #(
            .CAND_W (CAND_W),
            .DEPTH  (DEPTH),
            .IDX_W  (IDX_W)
         ) ring_i (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (accept),
            .wr_data (in_cand),
            .wr_idx  (wr_idx),
            .rd_idx  (res_tag),
            .rd_data (pick)
         );

         assign tag_in = wr_idx;

         AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> (res_tag != wr_idx)) else $error("live ring slot reused"); // R10
      end else begin : g_arith
         assign tag_in = in_cand[IDX_W-1:0];
         assign pick   = in_cand - CAND_W'(LATENCY);

         AST_ARITH_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
            (match_now && in_valid) |-> (pick[IDX_W-1:0] == res_tag)) else $error("counter recovery disagrees with tag"); // R8
      end
   endgenerate

   assign match_now = res_valid && (res_quality >= threshold) && !found_q;

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         found_q <= 1'b0;
      end else if (match_now) begin
         found_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (match_now && !restart) begin
         found_cand_q <= pick;
      end
   end

   assign found_valid = found_q;
   assign found_cand  = found_cand_q;

   // Cycles since reset or restart, saturating; used only by checks.
   always_ff @(posedge clk) begin
      if (rst || restart) begin
         warm_q <= '0;
      end else if (warm_q != WARM_W'(LATENCY)) begin
         warm_q <= warm_q + WARM_W'(1);
      end
   end

   AST_WARMUP_MASK: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (warm_q == WARM_W'(LATENCY))) else $error("result valid during fill"); // R2

   AST_FOUND_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(found_valid) |-> $past(res_valid && (res_quality >= threshold))) else $error("match without qualifying result"); // R4

   AST_FOUND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (found_valid && !restart) |=> (found_valid && $stable(found_cand))) else $error("found state moved"); // R6

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
      restart |=> (!found_valid && !res_valid && in_ready)) else $error("restart left state behind"); // R7

endmodule

// File: tb/cand_recovery_tracker_tb_top.sv
`timescale 1ns/1ps
module cand_recovery_tracker_tb_top;
   import crt_pkg::*;

   localparam int N_MAIN = 16;
   localparam int N_AR   = 4;
   localparam int CW     = 64;
   localparam int QW     = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst = 1'b1;
   logic          restart = 1'b0;
   logic [QW-1:0] thr = '1;
   logic          in_valid = 1'b0;
   logic [CW-1:0] in_cand = '0;
   logic          in_ready, res_valid, found_valid;
   logic [QW-1:0] res_quality;
   logic [CW-1:0] found_cand;

   logic          a_restart = 1'b0;
   logic [QW-1:0] a_thr = 16'd100;
   logic          a_in_valid = 1'b0;
   logic [CW-1:0] a_in_cand = '0;
   logic          a_in_ready, a_res_valid, a_found_valid;
   logic [QW-1:0] a_res_quality;
   logic [CW-1:0] a_found_cand;

   cand_recovery_tracker #(.LATENCY(N_MAIN), .CAND_W(CW), .QUAL_W(QW), .RECOVER(RECOVER_BUFFER)) dut_i (
      .clk(clk), .rst(rst), .restart(restart), .threshold(thr),
      .in_valid(in_valid), .in_cand(in_cand), .in_ready(in_ready),
      .res_valid(res_valid), .res_quality(res_quality),
      .found_valid(found_valid), .found_cand(found_cand));

   cand_recovery_tracker #(.LATENCY(N_AR), .CAND_W(CW), .QUAL_W(QW), .RECOVER(RECOVER_ARITH)) dut_arith_i (
      .clk(clk), .rst(rst), .restart(a_restart), .threshold(a_thr),
      .in_valid(a_in_valid), .in_cand(a_in_cand), .in_ready(a_in_ready),
      .res_valid(a_res_valid), .res_quality(a_res_quality),
      .found_valid(a_found_valid), .found_cand(a_found_cand));

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [CW-1:0] c;
      int unsigned   s;
   } item_t;
   item_t sb[$];

   int  checks = 0;
   int  fails = 0;
   bit  mon_on = 1'b0;
   bit  exp_found = 1'b0;
   bit  pending = 1'b0;
   bit  done = 1'b0;
   logic [CW-1:0] exp_cand = '0;

   task automatic chk(input bit ok, input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] mk(input logic [QW-1:0] q, input int salt);
      logic [15:0] h;
      h = 16'(salt * 40503 + 7);
      return {h, 32'(salt) * 32'h9E3779B1, q ^ h};
   endfunction

   function automatic logic [QW-1:0] score(input logic [CW-1:0] c);
      return c[15:0] ^ c[63:48];
   endfunction

   // Driver: present one cycle of stimulus, queue what the block will take.
   task automatic put(input bit v, input logic [CW-1:0] c);
      @(posedge clk);
      #1;
      in_valid = v;
      in_cand  = c;
      if (v && in_ready) begin
         item_t it;
         it.c = c;
         it.s = cyc;
         sb.push_back(it);
      end
   endtask

   task automatic do_restart();
      @(posedge clk);
      #1;
      mon_on   = 1'b0;
      in_valid = 1'b0;
      restart  = 1'b1;
      sb.delete();
      exp_found = 1'b0;
      pending   = 1'b0;
      @(posedge clk);
      #1;
      restart = 1'b0;
      mon_on  = 1'b1;
   endtask

   // Monitor: compares results and found state against the scoreboard.
   always @(negedge clk) begin
      if (mon_on && !rst) begin
         if (pending) begin
            chk(found_valid == 1'b1, "R4 found after match", 64'(found_valid), 64'd1);
            chk(found_cand == exp_cand, "R5 recovered candidate", found_cand, exp_cand);
            pending = 1'b0;
         end else if (exp_found) begin
            chk(found_valid == 1'b1 && found_cand == exp_cand, "R6 found holds", found_cand, exp_cand);
         end else begin
            chk(found_valid == 1'b0, "R4 no early match", 64'(found_valid), 64'd0);
         end
         if (sb.size() > 0 && sb[0].s + N_MAIN == cyc) begin
            item_t it;
            it = sb.pop_front();
            chk(res_valid == 1'b1, "R1 result timing", 64'(res_valid), 64'd1);
            chk(res_quality == score(it.c), "R1 result quality", 64'(res_quality), 64'(score(it.c)));
            if (!exp_found && score(it.c) >= thr) begin
               exp_found = 1'b1;
               exp_cand  = it.c;
               pending   = 1'b1;
            end
         end else begin
            chk(res_valid == 1'b0, "R3 R2 masked result", 64'(res_valid), 64'd0);
            chk(res_quality == '0, "R2 masked quality", 64'(res_quality), 64'd0);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      // R9 reset state
      chk(found_valid == 1'b0, "R9 found_valid", 64'(found_valid), 64'd0);
      chk(in_ready == 1'b1, "R9 in_ready", 64'(in_ready), 64'd1);
      chk(res_valid == 1'b0, "R9 res_valid", 64'(res_valid), 64'd0);
      mon_on = 1'b1;

      // Gapless stream then gapped stream, threshold out of reach.
      thr = 16'hFFFF;
      for (int i = 0; i < 30; i++) begin
         put(1'b1, mk(16'(i * 7), i + 1));
         if (i == 9) chk(res_valid == 1'b0, "R2 warmup", 64'(res_valid), 64'd0);
      end
      for (int i = 0; i < 30; i++) put(i % 3 != 0, mk(16'(i * 11 + 3), 100 + i));
      repeat (N_MAIN + 4) put(1'b0, '0);

      // Match at the exact threshold, with bubbles.
      thr = 16'h8000;
      for (int i = 0; i < 40; i++) begin
         logic [QW-1:0] q;
         if (i < 10)       q = 16'(16'h7FFF - i);
         else if (i == 10) q = 16'h8000;
         else              q = 16'hF000;
         put(i % 4 != 3, mk(q, 200 + i));
      end
      for (int j = 0; j < 30; j++) put(1'b1, mk(16'hF000, 500 + j));
      chk(in_ready == 1'b0, "R6 intake halted", 64'(in_ready), 64'd0);
      chk(found_cand == mk(16'h8000, 210), "R5 boundary match", found_cand, mk(16'h8000, 210));

      do_restart();
      chk(found_valid == 1'b0, "R7 found cleared", 64'(found_valid), 64'd0);
      chk(in_ready == 1'b1, "R7 ready again", 64'(in_ready), 64'd1);
      repeat (N_MAIN + 2) put(1'b0, '0);

      // One below threshold, then one above.
      thr = 16'h1234;
      for (int i = 0; i < 5; i++) put(1'b1, mk(16'h1233, 700 + i));
      put(1'b1, mk(16'h1235, 800));
      put(1'b1, mk(16'hFFFF, 801));
      repeat (N_MAIN + 8) put(1'b0, '0);
      chk(found_valid == 1'b1, "R4 above threshold", 64'(found_valid), 64'd1);
      chk(found_cand == mk(16'h1235, 800), "R5 first qualifier", found_cand, mk(16'h1235, 800));
      do_restart();
      repeat (N_MAIN + 2) put(1'b0, '0);

      // Arithmetic recovery with a gapless counter.
      for (int v = 90; v <= 130; v++) begin
         @(posedge clk);
         #1;
         a_in_valid = 1'b1;
         a_in_cand  = 64'(v);
      end
      chk(a_found_valid == 1'b1, "R8 arith found", 64'(a_found_valid), 64'd1);
      chk(a_found_cand == 64'd100, "R8 arith candidate", a_found_cand, 64'd100);
      chk(a_in_ready == 1'b0, "R6 arith intake halted", 64'(a_in_ready), 64'd0);
      @(posedge clk);
      #1;
      a_in_valid = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule